// File: doc/BRIEF.md
# Chip-Select Wait-State Generator

This block turns a 20-bit bus address into one of five active-low chip selects and tells the bus sequencer when the current access may end. Each region has its own configuration word. The word holds:

- an enable bit;
- a page range, in 1 KiB pages;
- a 2-bit wait-state count;
- a ready-mode bit, which either ignores the external ready line or requires it before the cycle can end.

The bus sequencer pulses `cyc_start` with the address of a new access. The block then decodes the address, latching the winning region and its timing, and asserts that region's select for the length of the access. The block raises `bus_rdy` during the last cycle of the access, and all selects drop at the following clock edge.

Region 0 is the lower-memory region. It always starts at address 0, and its upper page limit is clamped to the top of the lower half of the space. Regions 1 to 4 can be placed anywhere in the space. When ranges overlap, a fixed priority picks the region.

Top module: `csel_wait`

## Requirements
- R1: After reset every `cs_n` bit is 1 and `bus_rdy` is 0. Every region is disabled, with a wait count of 3 and ready required.
- R2: Configuration word layout: bit 23 is enable, bit 22 is ready-ignore, bits 21:20 are the wait count, bits 19:10 are the base page and bits 9:0 are the limit page. A page is `addr[19:10]`. With ready ignored, a wait field of W (00→0, 01→1, 10→2, 11→3 waits) raises `bus_rdy` exactly W cycles after the first cycle following the sampled `cyc_start`. That first cycle is cycle 0.
- R3: With ready required, `bus_rdy` rises in the first cycle that is at least W cycles in and in which `ext_rdy` is 1.
- R4: With ready ignored, a low `ext_rdy` never holds back `bus_rdy`.
- R5: A region matches when it is enabled and base ≤ page ≤ limit, both bounds inclusive. A disabled region never asserts its select.
- R6: Region 0 ignores its base field, always starts at page 0, and uses min(limit, 0x1FF) as its upper page.
- R7: At most one `cs_n` bit is 0 at any time. When regions overlap, the lowest-numbered matching region wins.
- R8: The winning select is low from cycle 0 through the cycle in which `bus_rdy` is 1. All selects are high at every other time.
- R9: An address that matches no region asserts no select, and `bus_rdy` rises in cycle 0 whatever the state of `ext_rdy`.
- R10: A `cyc_start` pulse that arrives while an access is in progress is ignored. The select and the end cycle stay unchanged.
- R11: Configuration writes made during an access do not change that access's select or end cycle. An index of 5 or above writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index of the write |
| cfg_data | input | 24 | Configuration word (layout in R2) |
| cyc_start | input | 1 | Start of a bus access, sampled at the clock edge |
| addr | input | 20 | Address of the access, valid with `cyc_start` |
| ext_rdy | input | 1 | External ready line |
| cs_n | output | 5 | Active-low chip selects, one per region |
| bus_rdy | output | 1 | The access may end at the coming clock edge |

## Verification
The bench drives `cyc_start` on a falling edge, so the rising edge that follows samples it. The next falling edge lies inside cycle 0. From there the bench counts cycles at falling edges, reading the outputs 1 ns after each edge, so it always reads settled register outputs. It expects `bus_rdy` in cycle W, or in cycle max(W, D) when ready is required and `ext_rdy` first goes high in cycle D. It expects the selects to be high one falling edge after the cycle in which `bus_rdy` was seen. The address sweep runs every page through a decoder written from R5 to R7 and compares the result with the select the block shows in cycle 0.

// File: rtl/csel_wait.sv
module csel_wait #(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 10,
  parameter int NREG   = 5,
  parameter int IDX_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic [4+2*(ADDR_W-PAGE_W)-1:0] cfg_data,
  input  logic                           cyc_start,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           ext_rdy,
  output logic [NREG-1:0]                cs_n,
  output logic                           bus_rdy
);
  localparam int PN_W  = ADDR_W - PAGE_W;
  localparam int CFG_W = 4 + 2*PN_W;
  localparam logic [PN_W-1:0] LOW_LIM = PN_W'((1 << (PN_W-1)) - 1);

  logic [NREG-1:0] en_q, ign_q;
  logic [1:0]      ws_q   [NREG];
  logic [PN_W-1:0] base_q [NREG];
  logic [PN_W-1:0] lim_q  [NREG];

  logic [PN_W-1:0] page;
  logic            unused_lo;
  assign page      = addr[ADDR_W-1:PAGE_W];
  assign unused_lo = ^addr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ign_q <= '0;
      for (int i = 0; i < NREG; i++) begin
        ws_q[i]   <= 2'b11;
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NREG; i++) begin
        if (int'(cfg_idx) == i) begin
          en_q[i]   <= cfg_data[CFG_W-1];
          ign_q[i]  <= cfg_data[CFG_W-2];
          ws_q[i]   <= cfg_data[CFG_W-3 -: 2];
          base_q[i] <= cfg_data[2*PN_W-1 -: PN_W];
          lim_q[i]  <= cfg_data[PN_W-1:0];
        end
      end
    end
  end

  logic [NREG-1:0] hit;
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_match
      if (g == 0) begin : g_low
        logic [PN_W-1:0] lim_eff;
        assign lim_eff = (lim_q[g] > LOW_LIM) ? LOW_LIM : lim_q[g];
        assign hit[g]  = en_q[g] && (page <= lim_eff);
      end else begin : g_any
        assign hit[g] = en_q[g] && (page >= base_q[g]) && (page <= lim_q[g]);
      end
    end
  endgenerate

  logic [NREG-1:0] win;
  logic [1:0]      win_ws;
  logic            win_ign;
  always_comb begin
    win     = '0;
    win_ws  = 2'd0;
    win_ign = 1'b1;
    for (int i = NREG-1; i >= 0; i--) begin
      if (hit[i]) begin
        win     = '0;
        win[i]  = 1'b1;
        win_ws  = ws_q[i];
        win_ign = ign_q[i];
      end
    end
  end

  logic            busy, ign_l;
  logic [1:0]      cnt;
  logic [NREG-1:0] sel;

  assign bus_rdy = busy && (cnt == 2'd0) && (ign_l || ext_rdy);
  assign cs_n    = ~(sel & {NREG{busy}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ign_l <= 1'b0;
      cnt   <= 2'd0;
      sel   <= '0;
    end else if (!busy) begin
      if (cyc_start) begin
        busy  <= 1'b1;
        sel   <= win;
        cnt   <= win_ws;
        ign_l <= win_ign;
      end
    end else if (bus_rdy) begin
      busy <= 1'b0;
      sel  <= '0;
    end else if (cnt != 2'd0) begin
      cnt <= cnt - 2'd1;
    end
  end

  logic [2:0] elapsed;
  logic [1:0] ws_chk;
  logic       ign_chk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      ws_chk  <= '0;
      ign_chk <= 1'b0;
    end else if (!busy && cyc_start) begin
      elapsed <= '0;
      ws_chk  <= win_ws;
      ign_chk <= win_ign;
    end else if (busy && elapsed != 3'd7) begin
      elapsed <= elapsed + 3'd1;
    end
  end

  // R2
  wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |-> (elapsed >= {1'b0, ws_chk}));
  // R3
  ready_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdy && !ign_chk) |-> ext_rdy);
  // R7
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> (&cs_n));
  // R10
  hold_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_rdy) |=> $stable(cs_n));
endmodule

// File: tb/csel_wait_test.sv
module csel_wait_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [23:0] cfg_data = '0;
  logic        cyc_start = 1'b0;
  logic [19:0] addr = '0;
  logic        ext_rdy = 1'b0;
  logic [4:0]  cs_n;
  logic        bus_rdy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  csel_wait uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
                 .cfg_data(cfg_data), .cyc_start(cyc_start), .addr(addr),
                 .ext_rdy(ext_rdy), .cs_n(cs_n), .bus_rdy(bus_rdy));

  always #2.5 clk = ~clk;

  logic        m_en  [5];
  logic [9:0]  m_base[5];
  logic [9:0]  m_lim [5];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input int idx, input bit en, input bit ign, input int ws,
                    input int base, input int lim);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx);
    cfg_data = {en, ign, 2'(ws), 10'(base), 10'(lim)};
    if (idx < 5) begin m_en[idx] = en; m_base[idx] = 10'(base); m_lim[idx] = 10'(lim); end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [4:0] exp_cs(input logic [9:0] p);
    logic [9:0] lo, hi;
    for (int i = 0; i < 5; i++) begin
      lo = (i == 0) ? 10'd0 : m_base[i];
      hi = (i == 0 && m_lim[i] > 10'h1FF) ? 10'h1FF : m_lim[i];
      if (m_en[i] && p >= lo && p <= hi) return ~(5'b1 << i);
    end
    return 5'h1F;
  endfunction

  // Starts an access; ext_rdy goes high from cycle rd. Returns end cycle and cycle-0 select.
  task automatic access(input logic [19:0] a, input int rd, output int endc,
                        output logic [4:0] cs0, input bit poke);
    @(negedge clk);
    addr = a; cyc_start = 1'b1;
    endc = -1;
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      cyc_start = 1'b0;
      ext_rdy = (w >= rd);
      if (poke && w == 1) begin
        cyc_start = 1'b1; addr = 20'hFFFFF;
        cfg_we = 1'b1; cfg_idx = 3'd3; cfg_data = {1'b1, 1'b1, 2'd0, 10'h200, 10'h27F};
      end else begin
        cfg_we = 1'b0;
      end
      #1;
      if (w == 0) cs0 = cs_n;
      if (poke && w > 0 && !bus_rdy) check(cs_n == cs0, "R10", cs_n, cs0);
      if (bus_rdy) begin endc = w; break; end
    end
    cyc_start = 1'b0; cfg_we = 1'b0;
    @(negedge clk); #1;
    check(cs_n == 5'h1F, "R8", cs_n, 5'h1F);
    ext_rdy = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    int endc;
    logic [4:0] cs0;
    for (int i = 0; i < 5; i++) begin m_en[i] = 0; m_base[i] = 0; m_lim[i] = 0; end
    #1;
    check(cs_n == 5'h1F && !bus_rdy, "R1", {cs_n, bus_rdy}, 6'h3E);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cs_n == 5'h1F && !bus_rdy, "R1", {cs_n, bus_rdy}, 6'h3E);

    // R9 with everything disabled
    access(20'h12345, 9, endc, cs0, 0);
    check(endc == 0 && cs0 == 5'h1F, "R9", endc, 0);

    // R2 R3 R4: timing sweep on region 3
    for (int ws = 0; ws < 4; ws++) begin
      for (int ign = 0; ign < 2; ign++) begin
        for (int rd = 0; rd < 6; rd += 2) begin
          int exp;
          wr(3, 1, ign[0], ws, 10'h200, 10'h27F);
          access(20'h80400, rd, endc, cs0, 0);
          exp = ign ? ws : (rd > ws ? rd : ws);
          check(endc == exp, ign ? "R4" : "R3", endc, exp);
          check(cs0 == 5'b10111, "R2", cs0, 5'b10111);
        end
      end
    end

    // R10 R11: restart pulse and config write mid-access, ws=3 ready ignored
    wr(3, 1, 1, 3, 10'h200, 10'h27F);
    access(20'h80400, 0, endc, cs0, 1);
    check(endc == 3, "R10", endc, 3);
    check(cs0 == 5'b10111, "R11", cs0, 5'b10111);
    access(20'h80400, 0, endc, cs0, 0);
    check(endc == 0, "R11", endc, 0);
    wr(6, 1, 1, 0, 0, 10'h3FF);
    access(20'h00000, 0, endc, cs0, 0);
    check(cs0 == 5'h1F && endc == 0, "R11", cs0, 5'h1F);

    // R5 R6 R7: page sweep
    wr(0, 1, 1, 0, 10'h300, 10'h3FF);
    wr(1, 1, 1, 0, 10'h3C0, 10'h3FF);
    wr(2, 1, 1, 0, 10'h100, 10'h17F);
    wr(3, 1, 1, 0, 10'h200, 10'h27F);
    wr(4, 0, 1, 0, 10'h280, 10'h2FF);
    for (int p = 0; p < 1024; p++) begin
      logic [4:0] e;
      e = exp_cs(10'(p));
      access({10'(p), 10'h155}, 0, endc, cs0, 0);
      check(cs0 == e, (p < 10'h200) ? "R6" : "R5", cs0, e);
      check($countones(~cs0) <= 1, "R7", cs0, e);
    end
    wr(0, 1, 1, 0, 0, 10'h0FF);
    for (int p = 10'h0F0; p < 10'h190; p++) begin
      logic [4:0] e;
      e = exp_cs(10'(p));
      access({10'(p), 10'h000}, 0, endc, cs0, 0);
      check(cs0 == e, "R7", cs0, e);
    end
    done = 1;
    summary();
  end
endmodule